// File: doc/BRIEF.md
# Triggered Oscilloscope Capture Buffer

This block turns a running stream of signed audio samples into a steady trace for a raster display. When vertical blanking begins, it starts looking for a rising zero crossing in the sample stream. From that point it stores one buffer of samples, one per visible pixel column. Because every stored window starts at a comparable phase of the waveform, the trace stays still from frame to frame. If no crossing arrives within one buffer's worth of samples, capture starts anyway, so a DC or noisy signal still gives a trace.

All writes happen inside vertical blanking. A buffer that is still incomplete when active video resumes is thrown away, and the previous trace stays on screen. During active video, the current pixel column is the read address. The synchronous memory read costs one clock, so the block also passes the column, line, active, sync and blanking signals through one register. The display logic then receives the amplitude and its pixel position in the same cycle. Each amplitude is stored as a row index: the top bits of the sample, flipped so that positive values are drawn higher on the screen, with zero near mid-screen.

One clock drives the whole block. The sample strobe acts as an enable.

Top module: `scope_capture`

## Requirements
- R1: A search starts when vertical blanking begins. In the search, a valid sample whose sign bit is 0 is a trigger if the valid sample just before it in the same search had its sign bit set. The trigger sample is stored at column 0, and the next valid samples are stored at columns 1, 2 and so on.
- R2: If NUM_COLS valid samples pass in a search without a trigger, the next valid sample starts the capture at column 0 anyway.
- R3: A search starts only in the clock cycle after the first cycle in which px_vblank_i is high following a cycle in which it was low. A sample that arrives in that first cycle, or earlier, is never examined.
- R4: The memory is written only while px_vblank_i is high. If px_vblank_i falls before NUM_COLS samples have been stored, that capture is dropped and the trace already on display does not change.
- R5: A capture that reaches NUM_COLS samples becomes the displayed trace at once and replaces the one before it. At most one capture starts per blanking interval.
- R6: A sample is shown as row = (2^(ROW_W-1) - 1) - S, where S is the signed value of its top ROW_W bits. With defaults, 0 gives 255, 0x800000 gives 511 and 0x7FFFFF gives 0.
- R7: When column c is presented on px_col_i, amp_row_o in the next cycle holds the row stored for column c.
- R8: col_o, line_o, active_o, hsync_o, vsync_o and vblank_o equal their px_* inputs delayed by exactly one clock.
- R9: Until the first capture completes, amp_row_o is 2^(ROW_W-1) - 1.
- R10: While rst_ni is low, amp_row_o is 2^(ROW_W-1) - 1, and all delayed timing outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | SAMPLE_W | Signed Q1.23 sample |
| px_col_i | input | COL_W | Current pixel column |
| px_line_i | input | LINE_W | Current pixel line |
| px_active_i | input | 1 | Active video |
| px_hsync_i | input | 1 | Horizontal sync |
| px_vsync_i | input | 1 | Vertical sync |
| px_vblank_i | input | 1 | Vertical blanking |
| amp_row_o | output | ROW_W | Trace row for the delayed column |
| col_o | output | COL_W | Column, delayed one clock |
| line_o | output | LINE_W | Line, delayed one clock |
| active_o | output | 1 | Active video, delayed one clock |
| hsync_o | output | 1 | Horizontal sync, delayed one clock |
| vsync_o | output | 1 | Vertical sync, delayed one clock |
| vblank_o | output | 1 | Vertical blanking, delayed one clock |

## Verification
The bench runs a sequence of frames, each fed by a different sample pattern:
- A rising ramp that wraps shows whether capture locks onto the rising crossing rather than the falling wrap.
- An always-positive stream can only be captured by the timeout path.
- A sparse strobe cannot fill the buffer before blanking ends, so the previous trace must survive.
- A cycle through the full-scale extremes and zero tests the row mapping and the sign test at its edges.
- A pseudo-random stream with a valid sample on every cycle, including the cycle blanking begins, shows whether that first sample is wrongly examined.

A behavioural model predicts every displayed row and every delayed timing signal, cycle by cycle.

// File: rtl/scope_pkg.sv
package scope_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEARCH  = 2'd1,
    ST_CAPTURE = 2'd2
  } scope_st_e;

  function automatic int unsigned mid_row(input int unsigned row_w);
    return (1 << (row_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/scope_trigger.sv
module scope_trigger
  import scope_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned NUM_COLS = 640,
  parameter int unsigned ROW_W    = 9,
  localparam int unsigned ADDR_W  = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int unsigned CNT_W   = $clog2(NUM_COLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vblank_i,
  input  logic              smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ROW_W-1:0]  wr_row_o,
  output logic              commit_o,
  output logic              busy_o
);
  localparam logic [ROW_W:0]    MID  = (ROW_W+1)'(mid_row(ROW_W));
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_COLS - 1);

  scope_st_e          st_q;
  logic               vb_q;
  logic               have_prev_q;
  logic               prev_neg_q;
  logic [CNT_W-1:0]   srch_q;
  logic [ADDR_W-1:0]  cap_q;

  logic cur_neg, vb_rise, timeout, edge_hit, hit, in_search, in_capture;
  logic signed [ROW_W:0] top_ext;
  logic [ROW_W:0]        row_ext;

  assign cur_neg    = smp_data_i[SAMPLE_W-1];
  assign vb_rise    = vblank_i & ~vb_q;
  assign in_search  = (st_q == ST_SEARCH);
  assign in_capture = (st_q == ST_CAPTURE);
  assign timeout    = (srch_q == CNT_W'(NUM_COLS));
  assign edge_hit   = have_prev_q & prev_neg_q & ~cur_neg;
  assign hit        = in_search & vblank_i & smp_valid_i & (edge_hit | timeout);

  assign wr_en_o   = vblank_i & smp_valid_i & (in_capture | hit);
  assign wr_addr_o = in_capture ? cap_q : '0;
  assign commit_o  = wr_en_o & (wr_addr_o == LAST);
  assign busy_o    = (st_q != ST_IDLE);

  // positive amplitude drawn towards row 0
  assign top_ext  = {smp_data_i[SAMPLE_W-1], smp_data_i[SAMPLE_W-1 -: ROW_W]};
  assign row_ext  = MID - top_ext;
  assign wr_row_o = row_ext[ROW_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      vb_q        <= 1'b0;
      have_prev_q <= 1'b0;
      prev_neg_q  <= 1'b0;
      srch_q      <= '0;
      cap_q       <= '0;
    end else begin
      vb_q <= vblank_i;
      unique case (st_q)
        ST_IDLE: begin
          if (vb_rise) begin
            st_q        <= ST_SEARCH;
            srch_q      <= '0;
            have_prev_q <= 1'b0;
          end
        end
        ST_SEARCH: begin
          if (!vblank_i) begin
            st_q <= ST_IDLE;
          end else if (smp_valid_i) begin
            if (hit) begin
              cap_q <= ADDR_W'(1);
              st_q  <= commit_o ? ST_IDLE : ST_CAPTURE;
            end else begin
              srch_q      <= srch_q + CNT_W'(1);
              have_prev_q <= 1'b1;
              prev_neg_q  <= cur_neg;
            end
          end
        end
        ST_CAPTURE: begin
          if (!vblank_i) begin
            st_q <= ST_IDLE;
          end else if (smp_valid_i) begin
            cap_q <= cap_q + ADDR_W'(1);
            if (commit_o) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scope_mem.sv
module scope_mem
  import scope_pkg::*;
#(
  parameter int unsigned NUM_COLS = 640,
  parameter int unsigned ROW_W    = 9,
  localparam int unsigned ADDR_W  = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ROW_W-1:0]  rd_row_o,
  output logic              show_bank_o,
  output logic              have_buf_o
);
  localparam logic [ROW_W-1:0] MID = ROW_W'(mid_row(ROW_W));

  logic                  show_q, have_q, sel_q, have_d_q;
  logic [1:0][ROW_W-1:0] rd_q;

  // bank g is written only while the other bank is on display
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [ROW_W-1:0] mem [NUM_COLS];
    logic [ROW_W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (show_q != 1'(g))) mem[wr_addr_i] <= wr_row_i;
      q <= mem[rd_addr_i];
    end
    assign rd_q[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      show_q   <= 1'b0;
      have_q   <= 1'b0;
      sel_q    <= 1'b0;
      have_d_q <= 1'b0;
    end else begin
      if (commit_i) begin
        show_q <= ~show_q;
        have_q <= 1'b1;
      end
      sel_q    <= show_q;
      have_d_q <= have_q;
    end
  end

  assign rd_row_o    = have_d_q ? rd_q[sel_q] : MID;
  assign show_bank_o = show_q;
  assign have_buf_o  = have_q;
endmodule

// File: rtl/scope_align.sv
module scope_align #(
  parameter int unsigned W   = 8,
  parameter int unsigned LAT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (LAT == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_pipe
    logic [W-1:0] stg_q [LAT];
    for (genvar s = 0; s < LAT; s++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
      end
    end
    assign q_o = stg_q[LAT-1];
  end
endmodule

// File: rtl/scope_capture.sv
module scope_capture
  import scope_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned NUM_COLS = 640,
  parameter int unsigned ROW_W    = 9,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned LINE_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  input  logic [COL_W-1:0]    px_col_i,
  input  logic [LINE_W-1:0]   px_line_i,
  input  logic                px_active_i,
  input  logic                px_hsync_i,
  input  logic                px_vsync_i,
  input  logic                px_vblank_i,
  output logic [ROW_W-1:0]    amp_row_o,
  output logic [COL_W-1:0]    col_o,
  output logic [LINE_W-1:0]   line_o,
  output logic                active_o,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                vblank_o
);
  localparam int unsigned ADDR_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int unsigned RD_LAT = 1;
  localparam int unsigned TW     = COL_W + LINE_W + 4;

  logic              wr_en, commit, busy, show_bank, have_buf;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [ROW_W-1:0]  wr_row;
  logic [TW-1:0]     tim_d, tim_q;

  scope_trigger #(
    .SAMPLE_W(SAMPLE_W), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W)
  ) u_trig (
    .clk_i, .rst_ni,
    .vblank_i   (px_vblank_i),
    .smp_valid_i, .smp_data_i,
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_row_o   (wr_row),
    .commit_o   (commit),
    .busy_o     (busy)
  );

  // columns past the buffer read entry 0; they are outside active video
  assign rd_addr = (32'(px_col_i) < NUM_COLS) ? px_col_i[ADDR_W-1:0] : '0;

  scope_mem #(.NUM_COLS(NUM_COLS), .ROW_W(ROW_W)) u_mem (
    .clk_i, .rst_ni,
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_row_i    (wr_row),
    .commit_i    (commit),
    .rd_addr_i   (rd_addr),
    .rd_row_o    (amp_row_o),
    .show_bank_o (show_bank),
    .have_buf_o  (have_buf)
  );

  assign tim_d = {px_col_i, px_line_i, px_active_i, px_hsync_i, px_vsync_i, px_vblank_i};

  scope_align #(.W(TW), .LAT(RD_LAT)) u_align (
    .clk_i, .rst_ni, .d_i(tim_d), .q_o(tim_q)
  );

  assign {col_o, line_o, active_o, hsync_o, vsync_o, vblank_o} = tim_q;
endmodule

// File: rtl/scope_capture_chk.sv
module scope_capture_chk #(
  parameter int unsigned NUM_COLS = 640,
  parameter int unsigned ROW_W    = 9,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned ADDR_W   = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              px_vblank_i,
  input logic              px_hsync_i,
  input logic [COL_W-1:0]  px_col_i,
  input logic              hsync_o,
  input logic [COL_W-1:0]  col_o,
  input logic [ROW_W-1:0]  amp_row_o,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              commit,
  input logic              busy,
  input logic              show_bank
);
  localparam logic [ROW_W-1:0] MID = ROW_W'((1 << (ROW_W - 1)) - 1);

  logic past_ok, seen1, seen2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      seen1   <= 1'b0;
      seen2   <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      seen1   <= seen1 | commit;
      seen2   <= seen1;
    end
  end

  p_wr_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> px_vblank_i);
  p_wr_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (32'(wr_addr) < NUM_COLS));
  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(busy)) |-> $past(px_vblank_i));
  p_swap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(commit)) |-> (show_bank != $past(show_bank)));
  p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(commit)) |-> $stable(show_bank));
  p_hsync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (hsync_o == $past(px_hsync_i)));
  p_col_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (col_o == $past(px_col_i)));
  p_mid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen2 |-> (amp_row_o == MID));
endmodule

bind scope_capture scope_capture_chk #(
  .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .px_vblank_i(px_vblank_i),
  .px_hsync_i(px_hsync_i), .px_col_i(px_col_i), .hsync_o(hsync_o),
  .col_o(col_o), .amp_row_o(amp_row_o), .wr_en(wr_en), .wr_addr(wr_addr),
  .commit(commit), .busy(busy), .show_bank(show_bank)
);

// File: tb/sim_scope_capture.sv
module sim_scope_capture;
  localparam int SW = 24, NC = 16, RW = 9, CW = 5, LW = 4;
  localparam int H_TOT = 24, V_TOT = 10, V_ACT = 6, NFR = 12;
  localparam int MID = (1 << (RW - 1)) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [SW-1:0] smp = '0;
  logic [CW-1:0] px_col = '0;
  logic [LW-1:0] px_line = '0;
  logic px_active = 1'b0, px_hsync = 1'b0, px_vsync = 1'b0, px_vblank = 1'b0;
  logic [RW-1:0] amp_row;
  logic [CW-1:0] col_o;
  logic [LW-1:0] line_o;
  logic active_o, hsync_o, vsync_o, vblank_o;

  always #2 clk = ~clk;

  scope_capture #(.SAMPLE_W(SW), .NUM_COLS(NC), .ROW_W(RW), .COL_W(CW), .LINE_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp),
    .px_col_i(px_col), .px_line_i(px_line), .px_active_i(px_active),
    .px_hsync_i(px_hsync), .px_vsync_i(px_vsync), .px_vblank_i(px_vblank),
    .amp_row_o(amp_row), .col_o(col_o), .line_o(line_o), .active_o(active_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .vblank_o(vblank_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, chk_en = 0;
  int cur_mode = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int shown[NC], cap[NC];
  bit shown_ok;
  string tag;
  int mst, k, n, prev;
  bit have_prev, vb_prev;
  int e_row, e_col, e_line;
  bit e_act, e_hs, e_vs, e_vb;

  function automatic int to_row(input logic [SW-1:0] v);
    int s;
    s = $signed(v);
    return MID - (s >>> (SW - RW));
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      1: return "R2";
      3: return "R6";
      4: return "R3";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; vb_prev = 0; shown_ok = 0; tag = "R9";
    end else begin
      e_row  = (shown_ok && px_col < NC) ? shown[px_col] : MID;
      e_col  = px_col; e_line = px_line;
      e_act  = px_active; e_hs = px_hsync; e_vs = px_vsync; e_vb = px_vblank;
      case (mst)
        0: if (px_vblank && !vb_prev) begin mst = 1; k = 0; have_prev = 0; end
        1: if (!px_vblank) begin
             mst = 0; if (shown_ok) tag = "R4";
           end else if (smp_valid) begin
             if ((have_prev && prev < 0 && $signed(smp) >= 0) || k == NC) begin
               cap[0] = to_row(smp); n = 1; mst = 2;
             end else begin
               k++; prev = $signed(smp); have_prev = 1;
             end
           end
        default: if (!px_vblank) begin
             mst = 0; if (shown_ok) tag = "R4";
           end else if (smp_valid) begin
             cap[n] = to_row(smp); n++;
             if (n == NC) begin
               tag = (cur_mode == 0 && shown_ok) ? "R5" : mode_tag(cur_mode);
               shown = cap; shown_ok = 1; mst = 0;
             end
           end
      endcase
      vb_prev = px_vblank;
    end
  end

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      check({col_o, line_o} == {CW'(e_col), LW'(e_line)}, "R8 col/line", {col_o, line_o}, {CW'(e_col), LW'(e_line)});
      check({active_o, hsync_o, vsync_o, vblank_o} == {e_act, e_hs, e_vs, e_vb}, "R8 ctl",
            {active_o, hsync_o, vsync_o, vblank_o}, {e_act, e_hs, e_vs, e_vb});
      if (active_o) check(amp_row == RW'(e_row), {"R7/", tag}, amp_row, e_row);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [SW-1:0] extremes [6] = '{24'h7FFFFF, 24'h800000, 24'h000000, 24'hFFFFFF, 24'h400000, 24'h00FFFF};

  initial begin
    int modes[NFR] = '{2, 0, 1, 2, 3, 4, 0, 2, 1, 3, 4, 0};
    int t = 0, ph = 0;
    logic [15:0] lfsr = 16'hACE1;
    repeat (4) @(negedge clk);
    check(amp_row == RW'(MID), "R10 row", amp_row, MID);
    check({col_o, line_o, active_o, hsync_o, vsync_o, vblank_o} == '0, "R10 timing",
          {col_o, line_o, active_o, hsync_o, vsync_o, vblank_o}, 0);
    rst_n = 1'b1;
    for (int f = 0; f < NFR; f++) begin
      for (int v = 0; v < V_TOT; v++) begin
        for (int h = 0; h < H_TOT; h++) begin
          @(negedge clk);
          chk_en = 1;
          cur_mode = modes[f];
          px_col = CW'(h); px_line = LW'(v);
          px_active = (h < NC) && (v < V_ACT);
          px_hsync = (h >= 18) && (h < 20);
          px_vsync = (v == 7);
          px_vblank = (v >= V_ACT);
          t++;
          case (modes[f])
            0: begin smp_valid = (t % 2 == 0); if (smp_valid) begin ph = (ph + 37) % 200; smp = SW'((ph - 100) <<< 16); end end
            1: begin smp_valid = (t % 2 == 0); smp = SW'(24'h100000 + (t % 64) * 24'h1000); end
            2: begin smp_valid = (t % 7 == 0); smp = SW'((t % 2) ? -24'sd300000 : 24'sd300000); end
            3: begin smp_valid = 1'b1; smp = extremes[t % 6]; end
            default: begin
              smp_valid = 1'b1;
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              smp = {lfsr, lfsr[7:0]};
            end
          endcase
        end
      end
    end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule